// File: doc/BRIEF.md
# H-Bridge Gate Command Decoder

This block turns a handful of logic inputs and control bits into registered on/off commands for the four gate drivers of two half-bridges. Each half-bridge has a high-side and a low-side transistor. A mode bit picks one of two schemes. In full-bridge mode the two half-bridges act as one H-bridge, steered by a PWM input, a direction input and two freewheel bits. In dual half-bridge mode each half-bridge follows its own input pin and has its own disable bit.

For every transistor that is commanded off, the block also reports how it is off. Active means the driver sinks the gate. Passive means the gate is released through its gate-source resistor. An output-enable bit is held in a latch that software sets and clears with one-cycle pulses. An active-low safety input clears that latch and forces every driver into active sink. A single abstract fault input also forces every driver into active off, but it leaves the latch as it is.

Top module: `hbridge_gate_cmd`

## Requirements
- R1: While reset is applied, and on the first cycle after it, `gate_on`, `off_passive`, `out_en` and `fail_safe` are all 0. The vectors are indexed as follows: bit 0 is high-side A, bit 1 is low-side A, bit 2 is high-side B, bit 3 is low-side B.
- R2: An `en_set` pulse while `safe_n` is high sets `out_en` on the next cycle. An `en_clr` pulse clears it on the next cycle, and `en_clr` wins when both pulses arrive together.
- R3: While `safe_n` is low, `fail_safe` is 1 and `out_en` is 0 from the next cycle on, and `en_set` has no effect. From the next cycle on, every gate is also off and actively sunk (`gate_on`=0, `off_passive`=0). Once `safe_n` is high again, `en_set` is accepted.
- R4: While `fault` is 1, the next cycle shows every gate actively off, and `out_en` keeps its value.
- R5: With `out_en` at 0 (and `safe_n` high), every gate is actively off.
- R6: In dual mode (`mode_dual`=1), when the block is enabled and a bridge's disable bit is 0, that bridge's high-side equals its input pin and its low-side equals the inverse, one cycle later.
- R7: In dual mode, when the block is enabled, a set disable bit turns both transistors of that bridge off passively.
- R8: In full-bridge mode (`mode_dual`=0), when the block is enabled and `pwm`=1, `dir`=0 turns on high-side A and low-side B (`gate_on`=4'b1001), and `dir`=1 turns on high-side B and low-side A (4'b0110). The other two transistors are actively off.
- R9: In full-bridge mode, when the block is enabled and `pwm`=0, `fw_high`=0 turns on both low-sides (4'b1010) and `fw_high`=1 turns on both high-sides (4'b0101).
- R10: During freewheel, the two transistors that are not freewheeling are actively off when `fw_active`=1 and passively off when `fw_active`=0.
- R11: Within one bridge the high-side and low-side are never on together, and no transistor is flagged passive while it is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_dual | input | 1 | 0: full-bridge decoding, 1: dual half-bridge decoding |
| safe_n | input | 1 | Active-low safety input |
| fault | input | 1 | Abstract fault indication, forces active off |
| en_set | input | 1 | Write pulse that sets the output-enable bit |
| en_clr | input | 1 | Write pulse that clears the output-enable bit |
| pwm | input | 1 | Full-bridge PWM input |
| dir | input | 1 | Full-bridge direction input |
| fw_high | input | 1 | Freewheel select: 0 both low-sides, 1 both high-sides |
| fw_active | input | 1 | Non-freewheeling transistors: 1 active off, 0 passive off |
| in_pin | input | 2 | Dual mode input per bridge (bit 0 is A, bit 1 is B) |
| dis | input | 2 | Dual mode disable per bridge (bit 0 is A, bit 1 is B) |
| gate_on | output | 4 | Registered on commands |
| off_passive | output | 4 | Registered passive-off flags |
| out_en | output | 1 | Latched output-enable bit |
| fail_safe | output | 1 | Fail-safe state indicator |

## Verification
The assertions assume that every input is synchronous to `clk` and is sampled once per edge, so a one-cycle pulse of `safe_n` or `fault` counts as a full safety event. The cross-conduction and passive-flag checks hold for any input values. The mode-specific checks apply only when `safe_n`, `fault` and `out_en` permit drive. The stimulus changes inputs only at the falling clock edge, so every input is steady across each rising edge. It walks through both modes, every PWM, direction and freewheel combination, the disable bits, and safety and fault events that overlap enable writes.

// File: rtl/hbg_pkg.sv
// Shared sizes and the command bundle used by the gate decoder.
// Assumes two half-bridges; gate index 2*b is high-side, 2*b+1 low-side.
package hbg_pkg;
    localparam int N_BR   = 2;
    localparam int N_GATE = 2 * N_BR;

    typedef struct packed {
        logic [N_GATE-1:0] on;
        logic [N_GATE-1:0] pas;
    } gate_cmd_t;
endpackage

// File: rtl/hbg_enable_latch.sv
// Output-enable latch and fail-safe indicator.
// Safety input low has priority, then the clear pulse, then the set pulse.
// Assumes all inputs synchronous to clk.
module hbg_enable_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic safe_n,
    input  logic en_set,
    input  logic en_clr,
    output logic out_en,
    output logic fail_safe
);
    // Latch update with safety priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_en    <= 1'b0;
            fail_safe <= 1'b0;
        end else begin
            fail_safe <= ~safe_n;
            if (!safe_n)      out_en <= 1'b0;
            else if (en_clr)  out_en <= 1'b0;
            else if (en_set)  out_en <= 1'b1;
        end
    end

    p_safe_clears_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !safe_n |=> (!out_en && fail_safe));
    p_clr_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        en_clr |=> !out_en);
    p_set_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (safe_n && en_set && !en_clr) |=> out_en);
endmodule

// File: rtl/hbg_full_decode.sv
// Full-bridge decode: the PWM active phase drives a diagonal chosen by dir,
// and the PWM inactive phase freewheels on the low-sides or the high-sides.
// Purely combinational; enable and safety gating happen in the top.
module hbg_full_decode
    import hbg_pkg::*;
(
    input  logic      pwm,
    input  logic      dir,
    input  logic      fw_high,
    input  logic      fw_active,
    output gate_cmd_t cmd
);
    localparam logic [N_GATE-1:0] DIAG_FWD = 4'b1001;
    localparam logic [N_GATE-1:0] DIAG_REV = 4'b0110;
    localparam logic [N_GATE-1:0] FW_LOW   = 4'b1010;
    localparam logic [N_GATE-1:0] FW_HIGH  = 4'b0101;

    // Pick the on pattern and the off style for this phase.
    always_comb begin
        if (pwm) begin
            cmd.on  = dir ? DIAG_REV : DIAG_FWD;
            cmd.pas = '0;
        end else begin
            cmd.on  = fw_high ? FW_HIGH : FW_LOW;
            cmd.pas = fw_active ? '0 : ~cmd.on;
        end
    end
endmodule

// File: rtl/hbg_dual_decode.sv
// Dual half-bridge decode: each bridge follows its own pin, and a set
// disable bit releases both of its transistors passively.
// Purely combinational; one slice per bridge.
module hbg_dual_decode
    import hbg_pkg::*;
(
    input  logic [N_BR-1:0] in_pin,
    input  logic [N_BR-1:0] dis,
    output gate_cmd_t       cmd
);
    for (genvar b = 0; b < N_BR; b++) begin : g_br
        // Complementary drive per bridge unless disabled.
        always_comb begin
            cmd.on[2*b]    = in_pin[b] & ~dis[b];
            cmd.on[2*b+1]  = ~in_pin[b] & ~dis[b];
            cmd.pas[2*b]   = dis[b];
            cmd.pas[2*b+1] = dis[b];
        end
    end
endmodule

// File: rtl/hbridge_gate_cmd.sv
// Gate command decoder top: selects full-bridge or dual decoding, gates the
// result with the enable latch, the safety input and the fault input, and
// registers the commands. Assumes inputs are synchronous to clk.
module hbridge_gate_cmd
    import hbg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_dual,
    input  logic             safe_n,
    input  logic             fault,
    input  logic             en_set,
    input  logic             en_clr,
    input  logic             pwm,
    input  logic             dir,
    input  logic             fw_high,
    input  logic             fw_active,
    input  logic [N_BR-1:0]  in_pin,
    input  logic [N_BR-1:0]  dis,
    output logic [N_GATE-1:0] gate_on,
    output logic [N_GATE-1:0] off_passive,
    output logic             out_en,
    output logic             fail_safe
);
    gate_cmd_t full_cmd, dual_cmd, next_cmd;
    logic      drive_ok;

    hbg_enable_latch u_latch (
        .clk(clk), .rst_n(rst_n), .safe_n(safe_n),
        .en_set(en_set), .en_clr(en_clr),
        .out_en(out_en), .fail_safe(fail_safe)
    );

    hbg_full_decode u_full (
        .pwm(pwm), .dir(dir), .fw_high(fw_high), .fw_active(fw_active),
        .cmd(full_cmd)
    );

    hbg_dual_decode u_dual (
        .in_pin(in_pin), .dis(dis), .cmd(dual_cmd)
    );

    // Drive is permitted only when enabled, safe and fault-free.
    assign drive_ok = out_en & safe_n & ~fault;

    // Select the decoder and force active off when drive is not permitted.
    always_comb begin
        next_cmd = mode_dual ? dual_cmd : full_cmd;
        if (!drive_ok) next_cmd = '0;
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_on     <= '0;
            off_passive <= '0;
        end else begin
            gate_on     <= next_cmd.on;
            off_passive <= next_cmd.pas;
        end
    end

    for (genvar b = 0; b < N_BR; b++) begin : g_chk
        p_no_shoot_through_r11: assert property (@(posedge clk) disable iff (!rst_n)
            !(gate_on[2*b] && gate_on[2*b+1]));
    end
    p_on_not_passive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_on & off_passive) == '0);
    p_fault_active_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (gate_on == '0 && off_passive == '0));
    p_fault_keeps_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && safe_n && !en_set && !en_clr) |=> (out_en == $past(out_en)));
    p_safe_active_sink_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !safe_n |=> (gate_on == '0 && off_passive == '0));
    p_dual_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_dual && drive_ok && !dis[0]) |=>
            (gate_on[0] == $past(in_pin[0]) && gate_on[1] == !$past(in_pin[0])));
    p_diag_fwd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_dual && drive_ok && pwm && !dir) |=> (gate_on == 4'b1001));
endmodule

// File: tb/hbridge_gate_cmd_test.sv
`timescale 1ns/1ps
module hbridge_gate_cmd_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_dual = 0, safe_n = 1, fault = 0, en_set = 0, en_clr = 0;
    logic pwm = 0, dir = 0, fw_high = 0, fw_active = 0;
    logic [1:0] in_pin = 0, dis = 0;
    logic [3:0] gate_on, off_passive;
    logic out_en, fail_safe;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    // model state
    bit m_en = 0, m_fs = 0;
    logic [3:0] m_on = 0, m_pas = 0;

    always #2 clk = ~clk;

    hbridge_gate_cmd uut (
        .clk(clk), .rst_n(rst_n), .mode_dual(mode_dual), .safe_n(safe_n),
        .fault(fault), .en_set(en_set), .en_clr(en_clr), .pwm(pwm), .dir(dir),
        .fw_high(fw_high), .fw_active(fw_active), .in_pin(in_pin), .dis(dis),
        .gate_on(gate_on), .off_passive(off_passive), .out_en(out_en),
        .fail_safe(fail_safe)
    );

    task automatic check(string tag);
        n_cmp++;
        if (gate_on !== m_on || off_passive !== m_pas || out_en !== m_en || fail_safe !== m_fs) begin
            n_bad++;
            $display("FAIL %s: got on=%b pas=%b en=%b fs=%b exp on=%b pas=%b en=%b fs=%b",
                     tag, gate_on, off_passive, out_en, fail_safe, m_on, m_pas, m_en, m_fs);
        end
    endtask

    // One clock: predict from the current inputs, step, then compare.
    task automatic step(string tag);
        bit nen;
        logic [3:0] non, npas;
        non = 0; npas = 0;
        if (!rst_n) begin
            nen = 0;
        end else begin
            if (m_en && safe_n && !fault) begin
                if (mode_dual) begin
                    for (int b = 0; b < 2; b++) begin
                        if (dis[b]) begin
                            npas[2*b] = 1; npas[2*b+1] = 1;
                        end else if (in_pin[b]) non[2*b] = 1;
                        else non[2*b+1] = 1;
                    end
                end else if (pwm) begin
                    non = dir ? 4'b0110 : 4'b1001;
                end else begin
                    non = fw_high ? 4'b0101 : 4'b1010;
                    if (!fw_active) npas = ~non;
                end
            end
            nen = m_en;
            if (!safe_n) nen = 0;
            else if (en_clr) nen = 0;
            else if (en_set) nen = 1;
        end
        @(posedge clk);
        m_fs = rst_n ? !safe_n : 0;
        m_en = nen; m_on = non; m_pas = npas;
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got hung exp finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step("R1 reset");
        en_set = 1; step("R1 reset ignores set");
        en_set = 0; rst_n = 1;
        step("R1 after reset");
        step("R5 disabled off active");
        en_set = 1; step("R2 set"); en_set = 0;
        // full-bridge patterns
        for (int k = 0; k < 16; k++) begin
            {pwm, dir, fw_high, fw_active} = 4'(k);
            step(pwm ? "R8 diagonal" : (fw_active ? "R9 freewheel" : "R10 freewheel passive"));
        end
        pwm = 0; fw_high = 1; fw_active = 0; step("R10 high freewheel passive");
        // dual mode
        mode_dual = 1;
        for (int k = 0; k < 16; k++) begin
            {dis, in_pin} = 4'(k);
            step(dis != 0 ? "R7 disable passive" : "R6 follow pin");
        end
        dis = 0; in_pin = 2'b01;
        // fault
        fault = 1; step("R4 fault off"); step("R4 fault keeps en");
        fault = 0; step("R6 after fault");
        // clear vs set
        en_set = 1; en_clr = 1; step("R2 clear wins");
        en_set = 0; en_clr = 0; step("R5 disabled");
        en_set = 1; step("R2 set again"); en_set = 0; step("R6 enabled");
        // safety
        safe_n = 0; step("R3 safe low");
        en_set = 1; step("R3 set ignored"); step("R3 still ignored");
        en_set = 0; safe_n = 1; step("R3 released en stays clear");
        en_set = 1; step("R3 set accepted"); en_set = 0;
        mode_dual = 0; pwm = 1; dir = 1; step("R8 reverse after safety");
        safe_n = 0; fault = 1; step("R3 safe and fault");
        safe_n = 1; fault = 0; step("R11 idle");
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule